// File: doc/BRIEF.md
# Framed Event Packet Transmitter

This block sends one stored event at a time over a 20-bit parallel link to a downstream collection module. Each event sits at the top of an external event stack. The stack presents a beam-clock timestamp, a level-1 event number, a payload length and a payload word that is read combinationally by address. A one-cycle start pulse, the enable-data request, begins a transfer. A transfer runs only when the block is idle and the stack reports that an event is available. The header fields and the length are captured at that moment.

The link carries two tag strobes beside the data bus: a control strobe and a data-valid strobe. A frame goes out in this order, one word per clock:

1. A leading control-strobe word with every data bit high.
2. A data-valid window holding the packet ID 0xDC111, the timestamp, the event number and then the payload words.
3. A trailing control-strobe word with every data bit low.

The block then pulses `done_o` and `pop_o` once, so the stack can drop the event it just sent, and returns to idle. A stack of up to five events is drained by issuing one start pulse per event.

Top module: `evt_frame_tx`

## Requirements
- R1: While reset is asserted, and in idle after it, `link_data_o` is 0 and `ctl_stb_o`, `dval_o`, `done_o` and `pop_o` are all low.
- R2: On the clock edge where idle sees `start_i` and `ev_avail_i` both high, the next cycle shows `ctl_stb_o`=1, `dval_o`=0 and `link_data_o`=0xFFFFF.
- R3: The cycle after the leading strobe drives `dval_o`=1 with `link_data_o`=0xDC111.
- R4: The next two cycles carry the timestamp and then the event number, both as captured at start. Later changes on `ev_stamp_i` and `ev_num_i` have no effect on the frame.
- R5: Payload words follow, one per clock, read at `pay_addr_o` = 0, 1, … up to `ev_len_i`−1. `dval_o` stays high without a gap from the packet ID word through the last payload word.
- R6: The cycle right after the last data-valid word drives `ctl_stb_o`=1, `dval_o`=0 and `link_data_o`=0. The zero word appears on the same cycle as the strobe.
- R7: The cycle after the trailing strobe pulses `done_o` and `pop_o` high for exactly one cycle. The block is idle on the cycle after that.
- R8: `start_i` has no effect while a frame is in progress, and none while `ev_avail_i` is low.
- R9: A payload length of 0 places the trailing strobe directly after the event-number word.
- R10: `ctl_stb_o` and `dval_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enable-data pulse that requests one frame |
| ev_avail_i | input | 1 | The stack holds at least one event |
| ev_stamp_i | input | 20 | Beam-clock timestamp of the top event |
| ev_num_i | input | 20 | Event number of the top event |
| ev_len_i | input | 4 | Payload word count of the top event |
| pay_addr_o | output | 4 | Payload word address into the top event |
| pay_data_i | input | 20 | Payload word at `pay_addr_o`, read combinationally |
| pop_o | output | 1 | Drop the sent event from the stack |
| link_data_o | output | 20 | Link data word |
| ctl_stb_o | output | 1 | Control strobe marking each end of the frame |
| dval_o | output | 1 | Data-valid strobe |
| done_o | output | 1 | Frame complete, one-cycle pulse |

## Verification
The assertions check the link framing on every cycle:
- the two strobes never overlap;
- each rise of data-valid is preceded by an all-ones control word and opens with the packet ID;
- each fall of data-valid lands on an all-zero control word;
- the done pulse lasts one cycle and sits right behind the trailing strobe;
- the payload address stays inside the captured length.

Only the bench scenarios can show the rest:
- the actual word contents and their order;
- that the header fields are captured at start;
- the zero-length and maximum-length frames;
- that start pulses are ignored while the block is busy or the stack is empty.

// File: rtl/evtx_pkg.sv
package evtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_ID, ST_STAMP, ST_EVNUM, ST_PAY, ST_TRAIL, ST_DONE
  } tx_state_e;
endpackage

// File: rtl/evtx_seq.sv
module evtx_seq
  import evtx_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ev_avail_i,
  input  logic [DATA_W-1:0] ev_stamp_i,
  input  logic [DATA_W-1:0] ev_num_i,
  input  logic [LEN_W-1:0]  ev_len_i,
  output tx_state_e         state_o,
  output logic [LEN_W-1:0]  pay_cnt_o,
  output logic [DATA_W-1:0] stamp_q_o,
  output logic [DATA_W-1:0] num_q_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  tx_state_e         state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] stamp_q, num_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      stamp_q <= '0;
      num_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i && ev_avail_i) begin
          state_q <= ST_LEAD;
          cnt_q   <= '0;
          len_q   <= ev_len_i;
          stamp_q <= ev_stamp_i;
          num_q   <= ev_num_i;
        end
        ST_LEAD:  state_q <= ST_ID;
        ST_ID:    state_q <= ST_STAMP;
        ST_STAMP: state_q <= ST_EVNUM;
        // empty payload skips straight to the trailer
        ST_EVNUM: state_q <= (len_q == '0) ? ST_TRAIL : ST_PAY;
        ST_PAY: begin
          if (cnt_q == len_q - ONE) state_q <= ST_TRAIL;
          else                      cnt_q   <= cnt_q + ONE;
        end
        ST_TRAIL: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign pay_cnt_o = cnt_q;
  assign stamp_q_o = stamp_q;
  assign num_q_o   = num_q;

  p_pay_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY) |-> (cnt_q < len_q));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ev_avail_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/evtx_word_mux.sv
module evtx_word_mux
  import evtx_pkg::*;
#(
  parameter int          DATA_W = 20,
  parameter logic [19:0] PKT_ID = 20'hDC111
) (
  input  tx_state_e         state_i,
  input  logic [DATA_W-1:0] stamp_i,
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] pay_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ctl_stb_o,
  output logic              dval_o,
  output logic              done_o
);
  always_comb begin
    data_o    = '0;
    ctl_stb_o = 1'b0;
    dval_o    = 1'b0;
    done_o    = 1'b0;
    case (state_i)
      ST_LEAD:  begin ctl_stb_o = 1'b1; data_o = '1; end
      ST_ID:    begin dval_o = 1'b1; data_o = DATA_W'(PKT_ID); end
      ST_STAMP: begin dval_o = 1'b1; data_o = stamp_i; end
      ST_EVNUM: begin dval_o = 1'b1; data_o = num_i; end
      ST_PAY:   begin dval_o = 1'b1; data_o = pay_data_i; end
      ST_TRAIL: ctl_stb_o = 1'b1;  // zero word on the strobe cycle itself
      ST_DONE:  done_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/evt_frame_tx.sv
module evt_frame_tx
  import evtx_pkg::*;
#(
  parameter int          DATA_W = 20,
  parameter int          LEN_W  = 4,
  parameter logic [19:0] PKT_ID = 20'hDC111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ev_avail_i,
  input  logic [DATA_W-1:0] ev_stamp_i,
  input  logic [DATA_W-1:0] ev_num_i,
  input  logic [LEN_W-1:0]  ev_len_i,
  output logic [LEN_W-1:0]  pay_addr_o,
  input  logic [DATA_W-1:0] pay_data_i,
  output logic              pop_o,
  output logic [DATA_W-1:0] link_data_o,
  output logic              ctl_stb_o,
  output logic              dval_o,
  output logic              done_o
);
  tx_state_e         state;
  logic [DATA_W-1:0] stamp_q, num_q;
  logic              done;

  evtx_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ev_avail_i (ev_avail_i),
    .ev_stamp_i (ev_stamp_i),
    .ev_num_i   (ev_num_i),
    .ev_len_i   (ev_len_i),
    .state_o    (state),
    .pay_cnt_o  (pay_addr_o),
    .stamp_q_o  (stamp_q),
    .num_q_o    (num_q)
  );

  evtx_word_mux #(.DATA_W(DATA_W), .PKT_ID(PKT_ID)) u_mux (
    .state_i    (state),
    .stamp_i    (stamp_q),
    .num_i      (num_q),
    .pay_data_i (pay_data_i),
    .data_o     (link_data_o),
    .ctl_stb_o  (ctl_stb_o),
    .dval_o     (dval_o),
    .done_o     (done)
  );

  assign done_o = done;
  assign pop_o  = done;

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_stb_o && dval_o));

  p_lead_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dval_o) |-> ($past(ctl_stb_o) && ($past(link_data_o) == '1)));

  p_id_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dval_o) |-> (link_data_o == DATA_W'(PKT_ID)));

  p_trail_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dval_o) |-> (ctl_stb_o && (link_data_o == '0)));

  p_done_after_trail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(ctl_stb_o) && !$past(dval_o) && ($past(link_data_o) == '0)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_evt_frame_tx.sv
module sim_evt_frame_tx;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [19:0] st;
    logic [19:0] nm;
    logic [3:0]  ln;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{st: 20'h00010, nm: 20'h00001, ln: 4'd3},
    '{st: 20'h00015, nm: 20'h00002, ln: 4'd0},
    '{st: 20'hABCDE, nm: 20'h00003, ln: 4'd1},
    '{st: 20'hFFFFF, nm: 20'h00004, ln: 4'd15},
    '{st: 20'h12345, nm: 20'h00000, ln: 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ev_avail = 1'b0;
  logic [19:0] ev_stamp = '0;
  logic [19:0] ev_num = '0;
  logic [3:0]  ev_len = '0;
  logic [3:0]  pay_addr;
  logic [19:0] pay_data;
  logic        pop, ctl_stb, dval, done;
  logic [19:0] link_data;
  logic [19:0] cur_num = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // stack model: payload word derived from event number and address
  assign pay_data = {cur_num[15:0], pay_addr};

  evt_frame_tx u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .ev_avail_i  (ev_avail),
    .ev_stamp_i  (ev_stamp),
    .ev_num_i    (ev_num),
    .ev_len_i    (ev_len),
    .pay_addr_o  (pay_addr),
    .pay_data_i  (pay_data),
    .pop_o       (pop),
    .link_data_o (link_data),
    .ctl_stb_o   (ctl_stb),
    .dval_o      (dval),
    .done_o      (done)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pack {ctl, dval, done, pop} with data for a single compare
  function automatic logic [23:0] obs();
    return {ctl_stb, dval, done, pop, link_data};
  endfunction

  task automatic chk_idle(input string req);
    chk(req, obs(), 24'h0);
  endtask

  task automatic run_frame(input vec_t v, input bit poke);
    @(negedge clk);
    ev_avail = 1'b1; ev_stamp = v.st; ev_num = v.nm; ev_len = v.ln;
    cur_num = v.nm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 lead", obs(), {4'b1000, 20'hFFFFF});
    ev_stamp = ~v.st; ev_num = ~v.nm;  // capture check for R4
    @(negedge clk);
    if (poke) start = 1'b1;            // R8 start while busy
    chk("R3 id", obs(), {4'b0100, 20'hDC111});
    @(negedge clk);
    start = 1'b0;
    chk("R4 stamp", obs(), {4'b0100, v.st});
    @(negedge clk);
    chk("R4 evnum", obs(), {4'b0100, v.nm});
    for (int i = 0; i < int'(v.ln); i++) begin
      @(negedge clk);
      chk("R5 payload", obs(), {4'b0100, v.nm[15:0], 4'(i)});
    end
    @(negedge clk);
    chk(v.ln == 0 ? "R9 trail" : "R6 trail", obs(), {4'b1000, 20'h0});
    @(negedge clk);
    chk("R7 done", obs(), {4'b0011, 20'h0});
    ev_avail = 1'b0;
    @(negedge clk);
    chk_idle("R7 idle after done");
    @(negedge clk);
    chk_idle("R8 no extra frame");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    chk_idle("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    foreach (VECS[k]) run_frame(VECS[k], 1'b0);

    // R8: start with empty stack is ignored
    @(negedge clk);
    ev_avail = 1'b0; start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_idle("R8 empty stack");
      chk("R10 strobe excl", {23'h0, ctl_stb & dval}, 24'h0);
    end
    start = 1'b0;

    // R8: start during frame is ignored
    run_frame('{st: 20'h0BEEF, nm: 20'h00007, ln: 4'd2}, 1'b1);

    // R1: reset mid-frame returns outputs to idle
    @(negedge clk);
    ev_avail = 1'b1; ev_len = 4'd8; cur_num = 20'h9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 mid payload dval", {23'h0, dval}, 24'h1);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 async reset");
    ev_avail = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule